// File: doc/BRIEF.md
# Integer ALU with Condition Flags

This block is the arithmetic and logic stage of a 32-bit execution pipeline. Two operands arrive already prepared: the second has passed through a barrel shifter upstream. A 4-bit opcode selects one of sixteen operations. There are eight bitwise operations and eight operations built on a single adder. The adder covers plain, reversed and carry-chained subtraction and addition. The result path is purely combinational. A write-enable tells the register file whether the result is to be stored.

Four status bits are held in a register: negative, zero, carry and overflow. They load at the rising clock edge when the caller requests a flag update and the destination is not the program counter. Four opcodes exist only to set flags: two tests and two compares. They compute like their ordinary counterparts but never enable the write. The carry rule depends on the class of operation. Bitwise operations take the carry from the shifter, or keep the stored carry after a null left shift. Adder operations take the carry out of the top bit.

Top module: `dp_alu_core`

## Requirements
- R1: Bitwise opcodes give these results: 0000 a AND b, 0001 a XOR b, 1100 a OR b, 1110 a AND NOT b, 1101 b, 1111 NOT b. Opcode 1000 computes like 0000 and opcode 1001 computes like 0001.
- R2: Adder opcodes give these results (C is `carry_in`): 0010 a-b, 0011 b-a, 0100 a+b, 0101 a+b+C, 0110 a-b+C-1, 0111 b-a+C-1. Opcode 1010 computes like 0010 and opcode 1011 computes like 0100.
- R3: `result_we` is low for opcodes 1000 through 1011 and high for all other opcodes.
- R4: On a flag update, N takes result bit 31, and Z is set only when all 32 result bits are zero. This holds for both classes of operation.
- R5: On a flag update by an adder opcode, C takes the adder carry out of bit 31, so after a subtract C=1 means no borrow. V is set when signed overflow into bit 31 occurs.
- R6: On a flag update by a bitwise opcode, C takes `shift_carry`. When `shift_null` is high, C keeps its stored value.
- R7: A flag update by a bitwise opcode leaves V unchanged.
- R8: The flags change only when `set_flags` is high and `dest_is_pc` is low. Otherwise all four flags hold their values.
- R9: A synchronous active-high reset clears all four flags to zero.
- R10: Opcodes 1101 and 1111 ignore operand a entirely.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst | input | 1 | Synchronous active-high reset |
| opcode | input | 4 | Operation select |
| op_a | input | 32 | First operand |
| op_b | input | 32 | Second operand, already shifted |
| carry_in | input | 1 | Carry used by the carry-chained adder opcodes |
| shift_carry | input | 1 | Carry out of the upstream shifter |
| shift_null | input | 1 | High when the shift was a left shift by zero |
| set_flags | input | 1 | Request to update the flags |
| dest_is_pc | input | 1 | Destination is the program counter; blocks the flag update |
| result | output | 32 | Combinational result |
| result_we | output | 1 | Result write-enable |
| flag_n | output | 1 | Negative flag |
| flag_z | output | 1 | Zero flag |
| flag_c | output | 1 | Carry flag |
| flag_v | output | 1 | Overflow flag |

## Verification
The flag register is the only state. A wrong flag value appears on the flag ports one clock after the update that wrote it. The bench checks every flag port after every operation, so such an error is seen at that edge. Any mismatch in the result or the write-enable is seen in the same cycle as the opcode. A flag that wrongly holds or wrongly changes shows up at the next sample. Because flags are checked even on non-updating cycles, it also carries forward into later comparisons.

// File: rtl/dp_alu_pkg.sv
`timescale 1ns/1ps
package dp_alu_pkg;

    localparam int unsigned DP_WIDTH = 32;

    typedef enum logic [3:0] {
        OP_AND   = 4'b0000,
        OP_XOR   = 4'b0001,
        OP_SUB   = 4'b0010,
        OP_RSUB  = 4'b0011,
        OP_ADD   = 4'b0100,
        OP_ADDC  = 4'b0101,
        OP_SUBC  = 4'b0110,
        OP_RSUBC = 4'b0111,
        OP_TAND  = 4'b1000,
        OP_TXOR  = 4'b1001,
        OP_CMP   = 4'b1010,
        OP_CMPN  = 4'b1011,
        OP_OR    = 4'b1100,
        OP_MOVE  = 4'b1101,
        OP_CLR   = 4'b1110,
        OP_NOTB  = 4'b1111
    } dp_op_e;

    typedef enum logic [1:0] {
        CIN_ZERO  = 2'd0,
        CIN_ONE   = 2'd1,
        CIN_CARRY = 2'd2
    } cin_sel_e;

    typedef struct packed {
        logic     swap;
        logic     inv;
        cin_sel_e cin;
    } adder_ctl_t;

    typedef struct packed {
        logic n;
        logic z;
        logic c;
        logic v;
    } dp_flags_t;

    function automatic logic op_is_bitwise(dp_op_e op);
        case (op)
            OP_AND, OP_XOR, OP_TAND, OP_TXOR,
            OP_OR, OP_MOVE, OP_CLR, OP_NOTB: return 1'b1;
            default:                         return 1'b0;
        endcase
    endfunction

    function automatic logic op_writes(dp_op_e op);
        return (op[3:2] != 2'b10);
    endfunction

    function automatic adder_ctl_t adder_decode(dp_op_e op);
        adder_ctl_t ctl;
        ctl.swap = (op == OP_RSUB) || (op == OP_RSUBC);
        case (op)
            OP_SUB, OP_RSUB, OP_CMP:    ctl.inv = 1'b1;
            OP_SUBC, OP_RSUBC:          ctl.inv = 1'b1;
            default:                    ctl.inv = 1'b0;
        endcase
        case (op)
            OP_SUB, OP_RSUB, OP_CMP:    ctl.cin = CIN_ONE;
            OP_ADDC, OP_SUBC, OP_RSUBC: ctl.cin = CIN_CARRY;
            default:                    ctl.cin = CIN_ZERO;
        endcase
        return ctl;
    endfunction

endpackage

// File: rtl/dp_bitwise_unit.sv
`timescale 1ns/1ps
module dp_bitwise_unit
    import dp_alu_pkg::*;
#(
    parameter int unsigned WIDTH = DP_WIDTH
) (
    input  dp_op_e             op,
    input  logic [WIDTH-1:0]   a,
    input  logic [WIDTH-1:0]   b,
    output logic [WIDTH-1:0]   y
);
    always_comb begin
        case (op)
            OP_AND, OP_TAND: y = a & b;
            OP_XOR, OP_TXOR: y = a ^ b;
            OP_OR:           y = a | b;
            OP_MOVE:         y = b;
            OP_CLR:          y = a & ~b;
            OP_NOTB:         y = ~b;
            default:         y = '0;
        endcase
    end
endmodule

// File: rtl/dp_addsub_unit.sv
`timescale 1ns/1ps
module dp_addsub_unit
    import dp_alu_pkg::*;
#(
    parameter int unsigned WIDTH = DP_WIDTH
) (
    input  adder_ctl_t         ctl,
    input  logic [WIDTH-1:0]   a,
    input  logic [WIDTH-1:0]   b,
    input  logic               carry_in,
    output logic [WIDTH-1:0]   sum,
    output logic               cout,
    output logic               ovf
);
    localparam int unsigned MSB = WIDTH - 1;

    logic [WIDTH-1:0] x;
    logic [WIDTH-1:0] y_raw;
    logic [WIDTH-1:0] y;
    logic             cin;
    logic [WIDTH:0]   total;

    always_comb begin
        x     = ctl.swap ? b : a;
        y_raw = ctl.swap ? a : b;
        y     = ctl.inv ? ~y_raw : y_raw;
        case (ctl.cin)
            CIN_ONE:   cin = 1'b1;
            CIN_CARRY: cin = carry_in;
            default:   cin = 1'b0;
        endcase
        total = {1'b0, x} + {1'b0, y} + {{WIDTH{1'b0}}, cin};
        sum   = total[MSB:0];
        cout  = total[WIDTH];
        ovf   = (x[MSB] == y[MSB]) && (total[MSB] != x[MSB]);
    end
endmodule

// File: rtl/dp_flag_reg.sv
`timescale 1ns/1ps
module dp_flag_reg
    import dp_alu_pkg::*;
(
    input  logic      clk,
    input  logic      rst,
    input  logic      load,
    input  dp_flags_t d,
    output dp_flags_t q
);
    always_ff @(posedge clk) begin
        if (rst)       q <= '0;
        else if (load) q <= d;
    end

    assert_reset_clear_R9: assert property (@(posedge clk)
        rst |=> (q == '0))
        else $error("flags not cleared by reset");

    assert_hold_without_load_R8: assert property (@(posedge clk) disable iff (rst)
        !load |=> $stable(q))
        else $error("flags moved without a load");
endmodule

// File: rtl/dp_alu_core.sv
`timescale 1ns/1ps
module dp_alu_core
    import dp_alu_pkg::*;
#(
    parameter int unsigned WIDTH = DP_WIDTH
) (
    input  logic             clk,
    input  logic             rst,
    input  logic [3:0]       opcode,
    input  logic [WIDTH-1:0] op_a,
    input  logic [WIDTH-1:0] op_b,
    input  logic             carry_in,
    input  logic             shift_carry,
    input  logic             shift_null,
    input  logic             set_flags,
    input  logic             dest_is_pc,
    output logic [WIDTH-1:0] result,
    output logic             result_we,
    output logic             flag_n,
    output logic             flag_z,
    output logic             flag_c,
    output logic             flag_v
);
    localparam int unsigned MSB = WIDTH - 1;

    dp_op_e           op;
    logic             bitwise;
    adder_ctl_t       actl;
    logic [WIDTH-1:0] bit_res;
    logic [WIDTH-1:0] add_res;
    logic             add_cout;
    logic             add_ovf;
    logic             update;
    dp_flags_t        cur_f;
    dp_flags_t        nxt_f;

    assign op      = dp_op_e'(opcode);
    assign bitwise = op_is_bitwise(op);
    assign actl    = adder_decode(op);

    dp_bitwise_unit #(.WIDTH(WIDTH)) u_bitwise (
        .op (op),
        .a  (op_a),
        .b  (op_b),
        .y  (bit_res)
    );

    dp_addsub_unit #(.WIDTH(WIDTH)) u_addsub (
        .ctl      (actl),
        .a        (op_a),
        .b        (op_b),
        .carry_in (carry_in),
        .sum      (add_res),
        .cout     (add_cout),
        .ovf      (add_ovf)
    );

    assign result    = bitwise ? bit_res : add_res;
    assign result_we = op_writes(op);
    assign update    = set_flags && !dest_is_pc;

    always_comb begin
        nxt_f.n = result[MSB];
        nxt_f.z = (result == '0);
        if (bitwise) begin
            nxt_f.c = shift_null ? cur_f.c : shift_carry;
            nxt_f.v = cur_f.v;
        end else begin
            nxt_f.c = add_cout;
            nxt_f.v = add_ovf;
        end
    end

    dp_flag_reg u_flags (
        .clk  (clk),
        .rst  (rst),
        .load (update),
        .d    (nxt_f),
        .q    (cur_f)
    );

    assign flag_n = cur_f.n;
    assign flag_z = cur_f.z;
    assign flag_c = cur_f.c;
    assign flag_v = cur_f.v;

    assert_test_no_write_R3: assert property (@(posedge clk) disable iff (rst)
        (opcode[3:2] == 2'b10) |-> !result_we)
        else $error("test or compare opcode enabled a write");

    assert_zero_flag_R4: assert property (@(posedge clk) disable iff (rst)
        update |=> (flag_z == ($past(result) == '0)))
        else $error("zero flag disagrees with result");

    assert_neg_flag_R4: assert property (@(posedge clk) disable iff (rst)
        update |=> (flag_n == $past(result[MSB])))
        else $error("negative flag disagrees with result");

    assert_bitwise_v_hold_R7: assert property (@(posedge clk) disable iff (rst)
        (update && bitwise) |=> $stable(flag_v))
        else $error("bitwise op changed overflow flag");

    assert_null_shift_c_hold_R6: assert property (@(posedge clk) disable iff (rst)
        (update && bitwise && shift_null) |=> $stable(flag_c))
        else $error("null shift changed carry flag");

    assert_pc_dest_hold_R8: assert property (@(posedge clk) disable iff (rst)
        dest_is_pc |=> $stable({flag_n, flag_z, flag_c, flag_v}))
        else $error("flags changed with program counter destination");
endmodule

// File: tb/dp_alu_core_bench.sv
`timescale 1ns/1ps
module dp_alu_core_bench;

    typedef struct {
        logic [3:0]  op;
        logic [31:0] res;
        logic        we;
        logic [3:0]  flags;
        logic        upd;
    } exp_item_t;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic [3:0]  opcode = '0;
    logic [31:0] op_a = '0;
    logic [31:0] op_b = '0;
    logic        carry_in = 1'b0;
    logic        shift_carry = 1'b0;
    logic        shift_null = 1'b0;
    logic        set_flags = 1'b0;
    logic        dest_is_pc = 1'b0;
    logic [31:0] result;
    logic        result_we;
    logic        flag_n, flag_z, flag_c, flag_v;

    int          checks = 0;
    int          errors = 0;
    logic [3:0]  model_f = 4'b0000;
    exp_item_t   sb_q[$];

    always #10 clk = ~clk;

    dp_alu_core u_dp_alu_core (
        .clk         (clk),
        .rst         (rst),
        .opcode      (opcode),
        .op_a        (op_a),
        .op_b        (op_b),
        .carry_in    (carry_in),
        .shift_carry (shift_carry),
        .shift_null  (shift_null),
        .set_flags   (set_flags),
        .dest_is_pc  (dest_is_pc),
        .result      (result),
        .result_we   (result_we),
        .flag_n      (flag_n),
        .flag_z      (flag_z),
        .flag_c      (flag_c),
        .flag_v      (flag_v)
    );

    task automatic check(input string req, input string what,
                         input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s %s: actual %h expected %h", req, what, act, exp);
        end
    endtask

    function automatic bit is_bitwise(logic [3:0] op);
        return (op[3:2] == 2'b00 && !op[1]) || op[3:2] == 2'b11 || op[3:1] == 3'b100;
    endfunction

    task automatic run_op(input logic [3:0] op, input logic [31:0] a, input logic [31:0] b,
                          input logic ci, input logic sc, input logic sn,
                          input logic sf, input logic pc);
        exp_item_t it;
        logic [31:0] r;
        logic c, v, add;
        logic [31:0] p, q;
        longint cin_l, u, s;
        @(negedge clk);
        opcode = op; op_a = a; op_b = b; carry_in = ci;
        shift_carry = sc; shift_null = sn; set_flags = sf; dest_is_pc = pc;
        c = model_f[1]; v = model_f[0]; r = '0;
        if (is_bitwise(op)) begin
            case (op)
                4'b0000, 4'b1000: r = a & b;
                4'b0001, 4'b1001: r = a ^ b;
                4'b1100:          r = a | b;
                4'b1101:          r = b;
                4'b1110:          r = a & ~b;
                default:          r = ~b;
            endcase
            c = sn ? model_f[1] : sc;
        end else begin
            p = a; q = b; add = 1'b0; cin_l = 0;
            case (op)
                4'b0011: begin p = b; q = a; end
                4'b0100, 4'b1011: add = 1'b1;
                4'b0101: begin add = 1'b1; cin_l = longint'(ci); end
                4'b0110: cin_l = longint'(!ci);
                4'b0111: begin p = b; q = a; cin_l = longint'(!ci); end
                default: ;
            endcase
            if (add) begin
                u = longint'(p) + longint'(q) + cin_l;
                s = longint'($signed(p)) + longint'($signed(q)) + cin_l;
                c = (u >= 64'sd4294967296);
            end else begin
                u = longint'(p) - longint'(q) - cin_l;
                s = longint'($signed(p)) - longint'($signed(q)) - cin_l;
                c = (u >= 0);
            end
            r = u[31:0];
            v = (s > 64'sd2147483647) || (s < -64'sd2147483648);
        end
        it.op = op; it.res = r; it.we = (op[3:2] != 2'b10);
        it.upd = sf && !pc;
        if (it.upd) model_f = {r[31], (r == 32'd0), c, v};
        it.flags = model_f;
        sb_q.push_back(it);
    endtask

    // Monitor: inputs are stable from the driving negedge; flags settle at the posedge.
    initial begin
        forever begin
            @(posedge clk);
            #2;
            if (sb_q.size() > 0) begin
                exp_item_t it;
                string rr, rc, rv;
                it = sb_q.pop_front();
                if (it.op == 4'b1101 || it.op == 4'b1111) rr = "R10";
                else if (is_bitwise(it.op)) rr = "R1";
                else rr = "R2";
                check(rr, "result", result, it.res);
                check("R3", "result_we", {31'd0, result_we}, {31'd0, it.we});
                if (!it.upd) begin
                    check("R8", "flags held", {28'd0, flag_n, flag_z, flag_c, flag_v}, {28'd0, it.flags});
                end else begin
                    rc = is_bitwise(it.op) ? "R6" : "R5";
                    rv = is_bitwise(it.op) ? "R7" : "R5";
                    check("R4", "flag_n", {31'd0, flag_n}, {31'd0, it.flags[3]});
                    check("R4", "flag_z", {31'd0, flag_z}, {31'd0, it.flags[2]});
                    check(rc, "flag_c", {31'd0, flag_c}, {31'd0, it.flags[1]});
                    check(rv, "flag_v", {31'd0, flag_v}, {31'd0, it.flags[0]});
                end
            end
        end
    end

    task automatic drain();
        while (sb_q.size() > 0) @(negedge clk);
        @(negedge clk);
    endtask

    initial begin
        repeat (20000) @(posedge clk);
        errors++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

    initial begin
        logic [31:0] corner [5];
        corner[0] = 32'h0000_0000; corner[1] = 32'h7FFF_FFFF; corner[2] = 32'h8000_0000;
        corner[3] = 32'hFFFF_FFFF; corner[4] = 32'h0000_0001;

        repeat (3) @(posedge clk);
        #2;
        // R9: flags are zero after reset
        check("R9", "flags after reset", {28'd0, flag_n, flag_z, flag_c, flag_v}, 32'd0);
        @(negedge clk);
        rst = 1'b0;

        // All opcodes against the corner operands with both carry-in values.
        for (int op = 0; op < 16; op++)
            for (int i = 0; i < 5; i++)
                for (int j = 0; j < 5; j++)
                    for (int ci = 0; ci < 2; ci++)
                        run_op(op[3:0], corner[i], corner[j], ci[0], 1'($urandom),
                               ($urandom % 4) == 0, 1'b1, 1'b0);

        // R10: move and NOT-b with differing operand a
        run_op(4'b1101, 32'hDEAD_BEEF, 32'h1234_5678, 1'b0, 1'b0, 1'b0, 1'b1, 1'b0);
        run_op(4'b1101, 32'h0000_0000, 32'h1234_5678, 1'b1, 1'b1, 1'b0, 1'b1, 1'b0);
        run_op(4'b1111, 32'hFFFF_FFFF, 32'h0F0F_0F0F, 1'b0, 1'b0, 1'b1, 1'b1, 1'b0);

        // R8: destination is the program counter, and flag update not requested
        run_op(4'b0010, 32'd5, 32'd5, 1'b0, 1'b1, 1'b0, 1'b1, 1'b1);
        run_op(4'b0100, 32'hFFFF_FFFF, 32'd1, 1'b0, 1'b0, 1'b0, 1'b0, 1'b0);

        // Random operands, random control
        for (int k = 0; k < 600; k++)
            run_op(4'($urandom), $urandom, $urandom, 1'($urandom), 1'($urandom),
                   1'($urandom), ($urandom % 4) != 0, ($urandom % 5) == 0);

        drain();
        // R9: reset in mid-run clears flags set to non-zero first
        run_op(4'b1010, 32'd0, 32'd1, 1'b0, 1'b0, 1'b0, 1'b1, 1'b0);
        drain();
        rst = 1'b1;
        model_f = 4'b0000;
        @(posedge clk);
        #2;
        check("R9", "flags after mid-run reset", {28'd0, flag_n, flag_z, flag_c, flag_v}, 32'd0);
        @(negedge clk);
        rst = 1'b0;
        run_op(4'b1101, 32'd0, 32'd0, 1'b0, 1'b1, 1'b1, 1'b1, 1'b0);
        drain();

        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

endmodule